// File: doc/BRIEF.md
# PHY calibration and DLL power-up sequencer

This block is a hardware sequencer for bringing up a storage-interface PHY. Work that would otherwise be a driver routine becomes a state machine. A power-on request does four things in order. It programs the pad drive strength and the output tap delay. It resets the PHY's internal calibration logic by holding the calibration power-down-bar low with the DLL off. It raises power-down-bar and waits for calibration to finish. It then writes a DLL frequency code and enables the DLL, and waits for the DLL to lock.

Both waits are timed in system clocks through a cycles-per-microsecond parameter, so each one has a hard deadline. A missed deadline ends the sequence with an error pulse and a cause code. The control outputs keep the values they had reached. A power-off request only drops power-down-bar and completes at once.

The frequency code comes from a measured card-clock rate given in MHz. The rate is divided by 50 and rounded to the nearest integer, halves rounding up. The result is clamped to 0..3. A warning flag reports a rate above the supported range.

Top module: `pcal_dll_seq`

## Requirements
- R1: A power-off request accepted in idle drives `cal_pdb` to 0 and pulses `done` in the next cycle. `busy` stays 0, and `dll_en`, `drv_code`, `otap_en` and `otap_sel` keep their values.
- R2: In the cycle after a power-on request is accepted, `drv_code` is 6, `otap_en` is 0, `otap_sel` is 4 and `busy` is 1.
- R3: During a power-on sequence, `dll_en` is 0 in every cycle in which `cal_pdb` is 0.
- R4: After a power-on request is accepted, `cal_pdb` stays 0 for exactly HOLD_US*CYC_PER_US cycles and then rises to 1.
- R5: After `cal_pdb` rises, `cal_done_i` must be sampled high at one of the next CAL_TMO_US*CYC_PER_US rising clock edges. Otherwise the block pulses `err` with `err_cause` = 1 (calibration timeout). On that error `cal_pdb` stays 1, `dll_en` stays 0, and `dll_frq` keeps its old value.
- R6: The frequency code is floor((rate_mhz+25)/50), clamped to 3. `rate_warn` is 1 when the unclamped value exceeds 3. The code appears on `dll_frq` in the cycle after `cal_done_i` is seen, and `dll_en` rises one cycle later.
- R7: After `dll_en` rises, `dll_rdy_i` must be sampled high at one of the next DLL_TMO_US*CYC_PER_US edges. If it is, `done` pulses in the following cycle. If it is not, `err` pulses with `err_cause` = 2 (DLL timeout) and `dll_en` stays 1.
- R8: Requests are ignored while `busy` is 1. When both requests arrive together in idle, power-off wins.
- R9: `done` and `err` each last one cycle and never occur together. `err_cause` and `rate_warn` hold their values until the next accepted request, which clears `err_cause` to 0.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_on | input | 1 | Power-on request, sampled in idle |
| req_off | input | 1 | Power-off request, sampled in idle |
| rate_mhz | input | RATE_W | Measured card-clock rate in MHz |
| cal_done_i | input | 1 | Calibration finished status from the PHY |
| dll_rdy_i | input | 1 | DLL locked status from the PHY |
| drv_code | output | 3 | Pad drive-strength code |
| otap_en | output | 1 | Output tap-delay enable |
| otap_sel | output | 4 | Output tap-delay select |
| cal_pdb | output | 1 | Calibration power-down-bar |
| dll_en | output | 1 | DLL enable |
| dll_frq | output | 3 | DLL frequency code |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle timeout pulse |
| err_cause | output | 2 | 0 none, 1 calibration timeout, 2 DLL timeout |
| rate_warn | output | 1 | Rate above the clampable range at last power-on |

## Verification
Some rules are checked on every cycle by the assertions. They cover the exact power-down hold length before `cal_pdb` rises and `dll_en` staying off while power-down-bar is low. They cover the order calibration-done, then frequency code, then DLL enable, and the frequency code staying in range. They also cover the one-cycle width and mutual exclusion of `done` and `err`, and the error cause staying put while busy.

Only the bench scenarios can show the other behaviour. These are the rounding and clamping boundaries of the rate (24/25, 74/75, 174/175 MHz). They are the off-by-one edges of both timeouts, a status arriving on the last allowed edge versus one edge late, and outputs left in place after each kind of timeout. They also include requests dropped during a sequence and power-off winning over a simultaneous power-on.

// File: rtl/pcal_pkg.sv
package pcal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HOLD = 3'd1,
        ST_CAL  = 3'd2,
        ST_FRQ  = 3'd3,
        ST_LOCK = 3'd4
    } seq_st_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_CAL  = 2'd1,
        CAUSE_DLL  = 2'd2
    } cause_e;

    typedef struct packed {
        logic [2:0] drv;
        logic       oen;
        logic [3:0] osel;
        logic       pdb;
        logic       den;
        logic [2:0] frq;
    } phy_ctl_t;

    localparam logic [2:0] DRV_NOMINAL = 3'd6;
    localparam logic [3:0] OSEL_NOMINAL = 4'd4;

    function automatic int unsigned cyc_of(int unsigned us, int unsigned per_us);
        return us * per_us;
    endfunction

endpackage

// File: rtl/pcal_timer.sv
module pcal_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R4, R5, R7: an expired timer stays expired until it is reloaded
    a_r4_timer_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (!load && zero) |=> zero);
endmodule

// File: rtl/pcal_freq.sv
module pcal_freq #(
    parameter int RATE_W   = 10,
    parameter int STEP_MHZ = 50,
    parameter int CODE_MAX = 3
) (
    input  logic [RATE_W-1:0] rate_mhz,
    output logic [2:0]        code,
    output logic              warn
);
    localparam int SW = RATE_W + 1;
    localparam logic [SW-1:0] HALF = SW'(STEP_MHZ / 2);
    localparam logic [SW-1:0] STEP = SW'(STEP_MHZ);
    localparam logic [SW-1:0] CMAX = SW'(CODE_MAX);

    logic [SW-1:0] sum;
    logic [SW-1:0] quot;

    always_comb begin
        sum  = {1'b0, rate_mhz} + HALF;
        quot = sum / STEP;
        warn = (quot > CMAX);
        code = warn ? 3'(CODE_MAX) : 3'(quot);
    end
endmodule

// File: rtl/pcal_fsm.sv
module pcal_fsm
    import pcal_pkg::*;
#(
    parameter int TW       = 8,
    parameter int HOLD_CYC = 10,
    parameter int CAL_CYC  = 100,
    parameter int DLL_CYC  = 200,
    parameter int CODE_MAX = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_on,
    input  logic          req_off,
    input  logic [2:0]    code_i,
    input  logic          warn_i,
    input  logic          cal_done_i,
    input  logic          dll_rdy_i,
    input  logic          tmr_zero,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output phy_ctl_t      ctl,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [1:0]    err_cause,
    output logic          rate_warn
);
    localparam logic [TW-1:0] HOLD_LD = TW'(HOLD_CYC - 1);
    localparam logic [TW-1:0] CAL_LD  = TW'(CAL_CYC - 1);
    localparam logic [TW-1:0] DLL_LD  = TW'(DLL_CYC - 1);

    seq_st_e    st;
    cause_e     cause_q;
    logic [2:0] code_q;
    logic       done_q, err_q, warn_q;

    always_comb begin
        tmr_load = ((st == ST_IDLE) && req_on && !req_off)
                || ((st == ST_HOLD) && tmr_zero)
                || (st == ST_FRQ);
        unique case (st)
            ST_IDLE: tmr_val = HOLD_LD;
            ST_HOLD: tmr_val = CAL_LD;
            default: tmr_val = DLL_LD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            ctl     <= '0;
            cause_q <= CAUSE_NONE;
            code_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            warn_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (req_off) begin
                        ctl.pdb <= 1'b0;
                        done_q  <= 1'b1;
                        cause_q <= CAUSE_NONE;
                        warn_q  <= 1'b0;
                    end else if (req_on) begin
                        ctl.pdb  <= 1'b0;
                        ctl.den  <= 1'b0;
                        ctl.drv  <= DRV_NOMINAL;
                        ctl.oen  <= 1'b0;
                        ctl.osel <= OSEL_NOMINAL;
                        cause_q  <= CAUSE_NONE;
                        warn_q   <= warn_i;
                        code_q   <= code_i;
                        st       <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (tmr_zero) begin
                        ctl.pdb <= 1'b1;
                        st      <= ST_CAL;
                    end
                end
                ST_CAL: begin
                    if (cal_done_i) begin
                        ctl.frq <= code_q;
                        st      <= ST_FRQ;
                    end else if (tmr_zero) begin
                        err_q   <= 1'b1;
                        cause_q <= CAUSE_CAL;
                        st      <= ST_IDLE;
                    end
                end
                ST_FRQ: begin
                    ctl.den <= 1'b1;
                    st      <= ST_LOCK;
                end
                ST_LOCK: begin
                    if (dll_rdy_i) begin
                        done_q <= 1'b1;
                        st     <= ST_IDLE;
                    end else if (tmr_zero) begin
                        err_q   <= 1'b1;
                        cause_q <= CAUSE_DLL;
                        st      <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (st != ST_IDLE);
    assign done      = done_q;
    assign err       = err_q;
    assign err_cause = cause_q;
    assign rate_warn = warn_q;

    // checker state: cycles power-down-bar has been low, saturating
    logic [TW-1:0] low_cnt;
    always_ff @(posedge clk) begin
        if (rst)                          low_cnt <= '0;
        else if (ctl.pdb)                 low_cnt <= '0;
        else if (low_cnt < TW'(HOLD_CYC)) low_cnt <= low_cnt + 1'b1;
    end

    a_r1_off_done: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_off) |=> (!ctl.pdb && done && !busy));
    a_r3_den_low: assert property (@(posedge clk) disable iff (rst)
        (busy && !ctl.pdb) |-> !ctl.den);
    a_r4_hold_len: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.pdb) |-> (low_cnt == TW'(HOLD_CYC)));
    a_r6_order: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.den) |-> ($past(cal_done_i, 2) && $stable(ctl.frq)));
    a_r6_range: assert property (@(posedge clk) disable iff (rst)
        ctl.frq <= 3'(CODE_MAX));
    a_r5_cause: assert property (@(posedge clk) disable iff (rst)
        err |-> (err_cause != 2'd0));
    a_r8_busy_keep: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(err_cause) || err));
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r9_err_pulse: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);
    a_r9_excl: assert property (@(posedge clk) disable iff (rst)
        !(done && err));
endmodule

// File: rtl/pcal_dll_seq.sv
module pcal_dll_seq
    import pcal_pkg::*;
#(
    parameter int CYC_PER_US = 250,
    parameter int HOLD_US    = 5,
    parameter int CAL_TMO_US = 50,
    parameter int DLL_TMO_US = 50000,
    parameter int RATE_W     = 10,
    parameter int STEP_MHZ   = 50,
    parameter int CODE_MAX   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_on,
    input  logic              req_off,
    input  logic [RATE_W-1:0] rate_mhz,
    input  logic              cal_done_i,
    input  logic              dll_rdy_i,
    output logic [2:0]        drv_code,
    output logic              otap_en,
    output logic [3:0]        otap_sel,
    output logic              cal_pdb,
    output logic              dll_en,
    output logic [2:0]        dll_frq,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [1:0]        err_cause,
    output logic              rate_warn
);
    localparam int HOLD_CYC = int'(cyc_of(HOLD_US, CYC_PER_US));
    localparam int CAL_CYC  = int'(cyc_of(CAL_TMO_US, CYC_PER_US));
    localparam int DLL_CYC  = int'(cyc_of(DLL_TMO_US, CYC_PER_US));
    localparam int MAX_A    = (HOLD_CYC > CAL_CYC) ? HOLD_CYC : CAL_CYC;
    localparam int MAX_CYC  = (MAX_A > DLL_CYC) ? MAX_A : DLL_CYC;
    localparam int TW       = $clog2(MAX_CYC + 1);

    logic [2:0]    code;
    logic          warn;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    phy_ctl_t      ctl;

    pcal_freq #(.RATE_W(RATE_W), .STEP_MHZ(STEP_MHZ), .CODE_MAX(CODE_MAX)) u_freq (
        .rate_mhz(rate_mhz), .code(code), .warn(warn)
    );

    pcal_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    pcal_fsm #(
        .TW(TW), .HOLD_CYC(HOLD_CYC), .CAL_CYC(CAL_CYC),
        .DLL_CYC(DLL_CYC), .CODE_MAX(CODE_MAX)
    ) u_fsm (
        .clk(clk), .rst(rst), .req_on(req_on), .req_off(req_off),
        .code_i(code), .warn_i(warn), .cal_done_i(cal_done_i), .dll_rdy_i(dll_rdy_i),
        .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .ctl(ctl), .busy(busy), .done(done), .err(err),
        .err_cause(err_cause), .rate_warn(rate_warn)
    );

    assign drv_code = ctl.drv;
    assign otap_en  = ctl.oen;
    assign otap_sel = ctl.osel;
    assign cal_pdb  = ctl.pdb;
    assign dll_en   = ctl.den;
    assign dll_frq  = ctl.frq;
endmodule

// File: tb/tb_pcal_dll_seq.sv
`timescale 1ns/1ps
module tb_pcal_dll_seq;
    localparam int CPU    = 2;
    localparam int HOLD_T = 5 * CPU;
    localparam int CAL_T  = 50 * CPU;
    localparam int DLL_T  = 100 * CPU;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_on = 1'b0, req_off = 1'b0;
    logic [9:0] rate_mhz = 10'd100;
    logic cal_done_i = 1'b0, dll_rdy_i = 1'b0;
    logic [2:0] drv_code, dll_frq;
    logic otap_en, cal_pdb, dll_en, busy, done, err, rate_warn;
    logic [3:0] otap_sel;
    logic [1:0] err_cause;

    always #2 clk = ~clk;

    pcal_dll_seq #(.CYC_PER_US(CPU), .HOLD_US(5), .CAL_TMO_US(50), .DLL_TMO_US(100)) dut (
        .clk(clk), .rst(rst), .req_on(req_on), .req_off(req_off), .rate_mhz(rate_mhz),
        .cal_done_i(cal_done_i), .dll_rdy_i(dll_rdy_i), .drv_code(drv_code),
        .otap_en(otap_en), .otap_sel(otap_sel), .cal_pdb(cal_pdb), .dll_en(dll_en),
        .dll_frq(dll_frq), .busy(busy), .done(done), .err(err),
        .err_cause(err_cause), .rate_warn(rate_warn)
    );

    int nchk = 0, nerr = 0, cyc = 0;
    bit started = 0, finished = 0;

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // PHY status model with programmable latency
    int cal_lat = 1, dll_lat = 1, ccnt = 0, dcnt = 0;
    always @(negedge clk) begin
        if (!cal_pdb) ccnt = 0; else ccnt++;
        if (!dll_en)  dcnt = 0; else dcnt++;
        cal_done_i = cal_pdb && (ccnt >= cal_lat);
        dll_rdy_i  = dll_en && (dcnt >= dll_lat);
    end

    // behavioural reference model, advanced at each rising edge
    int ph = 0, lowc = 0, waitc = 0, q;
    int m_drv = 0, m_oen = 0, m_osel = 0, m_pdb = 0, m_en = 0, m_frq = 0;
    int m_done = 0, m_err = 0, m_cause = 0, m_warn = 0, m_code = 0;
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            ph = 0; m_drv = 0; m_oen = 0; m_osel = 0; m_pdb = 0; m_en = 0; m_frq = 0;
            m_done = 0; m_err = 0; m_cause = 0; m_warn = 0; m_code = 0;
        end else begin
            m_done = 0; m_err = 0;
            case (ph)
                0: if (req_off) begin
                       m_pdb = 0; m_done = 1; m_cause = 0; m_warn = 0;
                   end else if (req_on) begin
                       m_pdb = 0; m_en = 0; m_drv = 6; m_oen = 0; m_osel = 4; m_cause = 0;
                       q = (int'(rate_mhz) + 25) / 50;
                       m_warn = (q > 3); m_code = (q > 3) ? 3 : q;
                       lowc = 0; ph = 1;
                   end
                1: begin lowc++; if (lowc == HOLD_T) begin m_pdb = 1; waitc = 0; ph = 2; end end
                2: begin
                       waitc++;
                       if (cal_done_i) begin m_frq = m_code; ph = 3; end
                       else if (waitc == CAL_T) begin m_err = 1; m_cause = 1; ph = 0; end
                   end
                3: begin m_en = 1; waitc = 0; ph = 4; end
                default: begin
                       waitc++;
                       if (dll_rdy_i) begin m_done = 1; ph = 0; end
                       else if (waitc == DLL_T) begin m_err = 1; m_cause = 2; ph = 0; end
                   end
            endcase
        end
        started = 1;
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (started && !finished) begin
            chk("R2 drv_code", drv_code, m_drv);
            chk("R2 otap_en", otap_en, m_oen);
            chk("R2 otap_sel", otap_sel, m_osel);
            chk("R4 cal_pdb", cal_pdb, m_pdb);
            chk("R3 dll_en", dll_en, m_en);
            chk("R6 dll_frq", dll_frq, m_frq);
            chk("R8 busy", busy, int'(ph != 0));
            chk("R9 done", done, m_done);
            chk("R9 err", err, m_err);
            chk("R5 err_cause", err_cause, m_cause);
            chk("R6 rate_warn", rate_warn, m_warn);
        end
    end

    task automatic summary();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL R9 watchdog: actual running expected finished");
        summary();
    end

    task automatic pulse(input bit on, input bit off);
        @(negedge clk); req_on = on; req_off = off;
        @(negedge clk); req_on = 0; req_off = 0;
    endtask

    task automatic wait_end();
        int n = 0;
        while (!(done || err) && n < 5000) begin @(negedge clk); n++; end
    endtask

    task automatic run_on(int r, int cl, int dl, int exp_done, int exp_cause,
                          int exp_frq, int exp_warn, string tag);
        rate_mhz = 10'(r); cal_lat = cl; dll_lat = dl;
        pulse(1, 0);
        chk({tag, " R2 busy"}, busy, 1);
        wait_end();
        chk({tag, " done"}, done, exp_done);
        chk({tag, " cause"}, err_cause, exp_cause);
        chk({tag, " frq"}, dll_frq, exp_frq);
        chk({tag, " warn"}, rate_warn, exp_warn);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R10 reset pdb", cal_pdb, 0);
        chk("R10 reset den", dll_en, 0);
        chk("R10 reset drv", drv_code, 0);
        chk("R10 reset busy", busy, 0);
        chk("R10 reset cause", err_cause, 0);

        run_on(100, 7, 20, 1, 0, 2, 0, "R6 rate100");
        chk("R2 drv6", drv_code, 6);
        chk("R2 oen0", otap_en, 0);
        chk("R2 osel4", otap_sel, 4);
        run_on(74, 3, 3, 1, 0, 1, 0, "R6 rate74");
        run_on(75, 3, 3, 1, 0, 2, 0, "R6 rate75");
        run_on(174, 3, 3, 1, 0, 3, 0, "R6 rate174");
        run_on(175, 3, 3, 1, 0, 3, 1, "R6 rate175");
        run_on(24, 3, 3, 1, 0, 0, 0, "R6 rate24");
        run_on(25, 3, 3, 1, 0, 1, 0, "R6 rate25");

        run_on(100, CAL_T, 5, 1, 0, 2, 0, "R5 cal_last_edge");
        run_on(10, CAL_T + 1, 5, 0, 1, 2, 0, "R5 cal_timeout");
        chk("R5 pdb kept", cal_pdb, 1);
        chk("R5 den kept", dll_en, 0);
        repeat (20) @(negedge clk);
        chk("R9 cause held", err_cause, 1);

        // request during busy is dropped
        rate_mhz = 10'd50; cal_lat = 5; dll_lat = 5;
        pulse(1, 0);
        repeat (3) @(negedge clk);
        pulse(0, 1);
        pulse(1, 0);
        wait_end();
        chk("R8 busy ignore done", done, 1);
        chk("R8 busy ignore frq", dll_frq, 1);
        @(negedge clk);

        run_on(100, 4, DLL_T, 1, 0, 2, 0, "R7 dll_last_edge");
        run_on(150, 4, DLL_T + 1, 0, 2, 3, 0, "R7 dll_timeout");
        chk("R7 den kept", dll_en, 1);

        pulse(0, 1);
        chk("R1 off done", done, 1);
        chk("R1 off pdb", cal_pdb, 0);
        chk("R1 off busy", busy, 0);
        chk("R1 off den kept", dll_en, 1);
        chk("R1 off drv kept", drv_code, 6);
        chk("R9 cause cleared", err_cause, 0);
        @(negedge clk);
        chk("R9 done one cycle", done, 0);

        pulse(1, 1);
        chk("R8 off wins done", done, 1);
        chk("R8 off wins busy", busy, 0);
        repeat (4) @(negedge clk);
        summary();
    end
endmodule